// File: doc/BRIEF.md
# Aging Page Replacement Selector

This block keeps a short history of recent use for each of a fixed set of page frames and, when asked, names the frame that looks least recently used. Each frame owns an aging counter. A periodic tick shifts every counter one place toward its least significant end and enters a one-bit "used in the last interval" flag at the most significant end. Recent activity therefore dominates the counter value, and older activity fades as it moves toward the low end.

Use reports arrive as single-cycle pulses on a per-frame input. They are collected into a sticky flag for each frame until the next tick samples them. The flags are then cleared, so each interval records only the references made during that interval. A victim request runs a combinational minimum search over all counters. The winning frame number is registered and marked valid one cycle later. When a frame has just been refilled, a per-frame clear input wipes its history.

Top module: `aging_victim_sel`

## Requirements
- R1: After reset every counter is zero, `victim_valid` is 0 and `victim_idx` is 0. A request made while all counters are zero selects frame 0.
- R2: On a cycle with `tick` high, each frame's counter becomes its old value shifted right by one bit, with that frame's used flag placed in bit CW-1.
- R3: A frame's used flag is set if `ref_hit` for that frame was pulsed in any cycle since the previous tick, including the tick cycle itself. A pulse that falls between ticks is not lost.
- R4: Once a tick has sampled a used flag, the flag is cleared. A following tick with no new hits enters 0 at bit CW-1.
- R5: Without a tick or a clear, every counter holds its value.
- R6: A request (`victim_req` high at an edge) makes `victim_valid` high for exactly the next cycle, with `victim_idx` set to the frame whose counter is smallest. `victim_valid` is 0 in every cycle that does not follow a request.
- R7: When several frames share the smallest counter value, the one with the lowest frame number is reported.
- R8: A request made in the same cycle as a tick is decided on the counter values from before that tick.
- R9: `clr_frame` bit i forces frame i's counter and used flag to zero. It overrides a tick and a hit in the same cycle.
- R10: A frame with many hits long ago ranks below a frame with a single recent hit, so the old frame is chosen as the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_hit | input | NFRAMES | Per-frame use pulses, bit i for frame i |
| tick | input | 1 | Aging interval strobe |
| clr_frame | input | NFRAMES | Per-frame history clear, bit i for frame i |
| victim_req | input | 1 | Request for a replacement candidate |
| victim_valid | output | 1 | High for one cycle after a request |
| victim_idx | output | $clog2(NFRAMES) | Selected frame number |

## Verification
The hardest case to reach is a tick, a hit and a request, sometimes together with a clear, all landing on the same edge, because the counters can only be seen through the victim choice. The stimulus table steers the counters into known orderings and then places a combined tick and request where the choice made before the tick differs from the choice after it. A clear is placed on a tick cycle where the same frame is also being hit. Hits pulsed between ticks are followed by a quiet tick and then a request, which shows that a hit is kept until the tick and then dropped.

// File: rtl/aging_victim_sel.sv
module aging_victim_sel #(
  parameter int NFRAMES = 8,
  parameter int CW      = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NFRAMES-1:0]                 ref_hit,
  input  logic                               tick,
  input  logic [NFRAMES-1:0]                 clr_frame,
  input  logic                               victim_req,
  output logic                               victim_valid,
  output logic [$clog2(NFRAMES)-1:0]         victim_idx
);
  localparam int IW = $clog2(NFRAMES);

  logic [CW-1:0]      age_q [NFRAMES];
  logic [NFRAMES-1:0] seen_q;
  logic [NFRAMES-1:0] used;
  logic [IW-1:0]      best_idx;
  logic [CW-1:0]      best_val;
  logic [CW-1:0]      win_q;
  logic               valid_q;
  logic [IW-1:0]      idx_q;

  assign used = seen_q | ref_hit;

  for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
    always_ff @(posedge clk) begin
      if (!rst_n || clr_frame[i]) begin
        age_q[i]  <= '0;
        seen_q[i] <= 1'b0;
      end else if (tick) begin
        age_q[i]  <= {used[i], age_q[i][CW-1:1]};
        seen_q[i] <= 1'b0;
      end else if (ref_hit[i]) begin
        seen_q[i] <= 1'b1;
      end
    end

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_frame[i]) && $past(rst_n) |-> age_q[i] == '0);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !clr_frame[i] |=> $stable(age_q[i]));

    assert_victim_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid |-> $past(age_q[i]) >= win_q);

    assert_tie_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      victim_valid && (victim_idx > IW'(i)) |-> $past(age_q[i]) > win_q);
  end

  always_comb begin
    best_idx = '0;
    best_val = age_q[0];
    for (int i = 1; i < NFRAMES; i++) begin
      if (age_q[i] < best_val) begin
        best_idx = IW'(i);
        best_val = age_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      win_q   <= '0;
    end else begin
      valid_q <= victim_req;
      if (victim_req) begin
        idx_q <= best_idx;
        win_q <= best_val;
      end
    end
  end

  assign victim_valid = valid_q;
  assign victim_idx   = idx_q;

  assert_valid_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> $past(victim_req));

  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_req |=> $stable(victim_idx));
endmodule

// File: tb/aging_victim_sel_tb.sv
module aging_victim_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ref_hit;
  logic       tick;
  logic [7:0] clr_frame;
  logic       victim_req;
  logic       victim_valid;
  logic [2:0] victim_idx;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  aging_victim_sel #(.NFRAMES(8), .CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_hit(ref_hit), .tick(tick),
    .clr_frame(clr_frame), .victim_req(victim_req),
    .victim_valid(victim_valid), .victim_idx(victim_idx)
  );

  // {clr[7:0], hits[7:0], tick, req, expected idx[2:0]}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {8'h00, 8'h01, 1'b1, 1'b0, 3'd0},  // R2 cnt0=80
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd1},  // R7 tie among 1..7
    {8'h00, 8'h02, 1'b1, 1'b0, 3'd0},
    {8'h00, 8'hFC, 1'b1, 1'b0, 3'd0},  // 20,40,80..
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd0},  // R2 min frame0=20
    {8'h00, 8'h01, 1'b1, 1'b0, 3'd0},  // 90,20,40..
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd1},  // R2
    {8'h00, 8'h02, 1'b1, 1'b1, 3'd1},  // R8 pre-tick values
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd2},  // R8 post-tick 48,90,20..
    {8'h00, 8'h04, 1'b0, 1'b0, 3'd0},  // R3 hit between ticks
    {8'h00, 8'h00, 1'b1, 1'b0, 3'd0},  // 24,48,90,10..
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd3},  // R3 R5
    {8'h00, 8'h00, 1'b1, 1'b0, 3'd0},  // R4 12,24,48,08..
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd3},  // R4
    {8'h00, 8'h7E, 1'b1, 1'b0, 3'd0},  // 09,92,A4,84x4,04
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd7},  // R10
    {8'h01, 8'h01, 1'b1, 1'b0, 3'd0},  // R9 clr wins: 00,49,52,42x4,02
    {8'h00, 8'h00, 1'b0, 1'b1, 3'd0}   // R9
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] c, input logic [7:0] h, input logic t,
                      input logic r, input logic [2:0] e);
    clr_frame = c; ref_hit = h; tick = t; victim_req = r;
    @(posedge clk);
    @(negedge clk);
    clr_frame = '0; ref_hit = '0; tick = 1'b0; victim_req = 1'b0;
    if (r) begin
      check(victim_valid === 1'b1, "R6 valid", int'(victim_valid), 1);
      check(victim_idx === e, "R6/R7/R8/R10 victim", int'(victim_idx), int'(e));
      @(posedge clk);
      @(negedge clk);
      check(victim_valid === 1'b0, "R6 single pulse", int'(victim_valid), 0);
    end else begin
      check(victim_valid === 1'b0, "R6 no request", int'(victim_valid), 0);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_hit = '0; tick = 1'b0; clr_frame = '0; victim_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(victim_valid === 1'b0, "R1 reset valid", int'(victim_valid), 0);
    check(victim_idx === 3'd0, "R1 reset idx", int'(victim_idx), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++)
      step(VEC[k][20:13], VEC[k][12:5], VEC[k][4], VEC[k][3], VEC[k][2:0]);

    // R1: reset mid-run clears all history
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(victim_valid === 1'b0 && victim_idx === 3'd0, "R1 re-reset",
          int'(victim_idx), 0);
    rst_n = 1'b1;
    step(8'h00, 8'h00, 1'b0, 1'b1, 3'd0);  // R1 all zero -> frame 0

    // R4 directed: frame0 hit once, two quiet ticks -> 0x20; others hit recently
    step(8'h00, 8'h01, 1'b1, 1'b0, 3'd0);
    step(8'h00, 8'h00, 1'b1, 1'b0, 3'd0);
    step(8'h00, 8'h00, 1'b1, 1'b0, 3'd0);
    step(8'h00, 8'hFE, 1'b1, 1'b0, 3'd0);  // 10 vs 80
    step(8'h00, 8'h00, 1'b0, 1'b1, 3'd0);  // R4 R10

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule